// File: doc/BRIEF.md
# Per-Pixel Digital Gain Realignment

An image front end amplifies each pixel by x1, x2, x4 or x8 before conversion, picking the gain so that every pixel uses as much of the converter range as it can. This block undoes that gain in the digital domain. It takes the 10-bit converter sample and shifts it right by 0, 1, 2 or 3 bits to match the analog gain that pixel received. Three zero fraction bits are appended before the shift, so no low-order information is discarded. The result is a 13-bit extended-dynamic-range word.

The gain code is presented when the analog gain is applied. The sample arrives a fixed number of converter pipeline cycles later. An internal delay line lines the two up, so each pixel is shifted by its own gain. A fixed-gain override replaces the per-pixel code with a configured code. A narrow mode serves the 9-bit preview and 6-bit low-power conversions: it keeps only bits [12:4] and forces the low four bits to zero.

Top module: `gain_realign`

## Requirements
- R1: While reset is held and after its release, `valid_o` is 0 and `word_o` is 0 until the first accepted sample.
- R2: Gain code 0, 1, 2 and 3 means x1, x2, x4 and x8. The output word is `{sample, 3'b000}` shifted right by the code value (for example, sample 10'h333 gives 13'h0333 at code 3 and 13'h1998 at code 0).
- R3: The automatic gain for a sample is the `vga_gain_i` value presented exactly `ADC_LAT` (default 3) cycles before that sample's `adc_valid_i` cycle. The code is sampled every cycle, even when no sample is valid.
- R4: When `fix_en_i` is 1, the shift uses `fix_gain_i` (same encoding as R2) and the per-pixel code has no effect on the output.
- R5: When `narrow_i` is 1 with a valid sample, `word_o[3:0]` is 0 and `word_o[12:4]` equals the same bits of the full-precision result.
- R6: `valid_o` is high in the cycle after `adc_valid_i` was high, and only then. The word belongs to that sample.
- R7: In a cycle after `adc_valid_i` was low, `word_o` keeps its previous value.
- R8: At x1 with full precision, all 10 sample bits appear unchanged in `word_o[12:3]`. At x8, `word_o[12:10]` is 0. All-zero and all-one samples follow R2 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vga_gain_i | input | 2 | Gain code applied by the analog amplifier this cycle |
| adc_data_i | input | 10 | Converter sample |
| adc_valid_i | input | 1 | Sample valid |
| fix_en_i | input | 1 | Use the fixed gain instead of the per-pixel code |
| fix_gain_i | input | 2 | Fixed gain code |
| narrow_i | input | 1 | 9-bit output mode (preview or 6-bit conversion) |
| word_o | output | 13 | Realigned 13-bit word |
| valid_o | output | 1 | Output word valid |

## Verification
The assertions check on every cycle that `valid_o` follows the sample valid by one cycle and that the word holds between samples. They also check that narrow mode clears the low nibble, that x1 passes the sample through unchanged and that x8 clears the top three bits. Only the scoreboard scenarios can show the rest. These are that each pixel is shifted by the code presented exactly `ADC_LAT` cycles earlier while the code changes every cycle, and that the fixed override truly ignores the per-pixel code. They also cover that every shift value produces the exact expected word.

// File: rtl/gr_pkg.sv
// Shared definitions for the gain realignment block.
// Assumes a 2-bit gain code whose value equals the right-shift amount.
package gr_pkg;
    localparam int GAIN_W = 2;
    localparam int NUM_GAINS = 1 << GAIN_W;

    typedef enum logic [GAIN_W-1:0] {
        GAIN_X1 = 2'd0,
        GAIN_X2 = 2'd1,
        GAIN_X4 = 2'd2,
        GAIN_X8 = 2'd3
    } gain_e;
endpackage

// File: rtl/gr_gain_delay.sv
// Delay line that carries the per-pixel gain code alongside the converter
// pipeline. Assumes LAT >= 1. The code enters every cycle, so the output equals
// the input from LAT cycles earlier.
module gr_gain_delay #(
    parameter int LAT = 3,
    parameter int W   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [LAT];

    genvar k;
    generate
        for (k = 0; k < LAT; k++) begin : g_stage
            if (k == 0) begin : g_head
                // capture the incoming gain code
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d_i;
                end
            end else begin : g_body
                // advance the code one pipeline step
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[k] <= '0;
                    else        stage[k] <= stage[k-1];
                end
            end
        end
    endgenerate

    assign q_o = stage[LAT-1];
endmodule

// File: rtl/gr_gain_select.sv
// Chooses the effective gain code: the configured fixed code when the
// override is on, otherwise the delayed per-pixel code. Purely combinational.
module gr_gain_select
    import gr_pkg::*;
(
    input  logic       fix_en_i,
    input  gain_e      fix_gain_i,
    input  gain_e      auto_gain_i,
    output gain_e      eff_gain_o
);
    // pick fixed or automatic gain
    always_comb begin
        if (fix_en_i) eff_gain_o = fix_gain_i;
        else          eff_gain_o = auto_gain_i;
    end
endmodule

// File: rtl/gr_shift_unit.sv
// Extends the sample with FRAC_W zero bits, shifts right by the gain code, and
// clears the DROP_W low bits in narrow mode. Assumes NUM_GAINS-1 <= FRAC_W.
module gr_shift_unit
    import gr_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int FRAC_W   = 3,
    parameter int DROP_W   = 4,
    localparam int WORD_W  = SAMPLE_W + FRAC_W
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  gain_e               gain_i,
    input  logic                narrow_i,
    output logic [WORD_W-1:0]   word_o
);
    logic [WORD_W-1:0] ext;
    logic [WORD_W-1:0] cand [NUM_GAINS];
    logic [WORD_W-1:0] shifted;

    assign ext = {sample_i, {FRAC_W{1'b0}}};

    genvar s, b;
    generate
        for (s = 0; s < NUM_GAINS; s++) begin : g_cand
            assign cand[s] = ext >> s;
        end
    endgenerate

    // select the candidate matching the gain code
    always_comb begin
        shifted = cand[gain_i];
    end

    generate
        for (b = 0; b < WORD_W; b++) begin : g_mask
            if (b < DROP_W) begin : g_low
                assign word_o[b] = narrow_i ? 1'b0 : shifted[b];
            end else begin : g_high
                assign word_o[b] = shifted[b];
            end
        end
    endgenerate
endmodule

// File: rtl/gain_realign.sv
// Top of the per-pixel gain realignment block. Assumes the gain code for a
// pixel is presented ADC_LAT cycles before its sample. Output latency is one
// register stage. The word holds between samples.
module gain_realign
    import gr_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int FRAC_W   = 3,
    parameter int DROP_W   = 4,
    parameter int ADC_LAT  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 vga_gain_i,
    input  logic [SAMPLE_W-1:0]        adc_data_i,
    input  logic                       adc_valid_i,
    input  logic                       fix_en_i,
    input  logic [1:0]                 fix_gain_i,
    input  logic                       narrow_i,
    output logic [SAMPLE_W+FRAC_W-1:0] word_o,
    output logic                       valid_o
);
    localparam int WORD_W = SAMPLE_W + FRAC_W;

    logic [GAIN_W-1:0] aligned_gain;
    gain_e             eff_gain;
    logic [WORD_W-1:0] next_word;

    gr_gain_delay #(.LAT(ADC_LAT), .W(GAIN_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (vga_gain_i),
        .q_o   (aligned_gain)
    );

    gr_gain_select u_sel (
        .fix_en_i    (fix_en_i),
        .fix_gain_i  (gain_e'(fix_gain_i)),
        .auto_gain_i (gain_e'(aligned_gain)),
        .eff_gain_o  (eff_gain)
    );

    gr_shift_unit #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .DROP_W(DROP_W)) u_shf (
        .sample_i (adc_data_i),
        .gain_i   (eff_gain),
        .narrow_i (narrow_i),
        .word_o   (next_word)
    );

    // register the realigned word on each valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= adc_valid_i;
            if (adc_valid_i) word_o <= next_word;
        end
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(adc_valid_i)));

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_valid_i |=> $stable(word_o));

    // R5
    narrow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_valid_i && narrow_i) |=> (word_o[DROP_W-1:0] == '0));

    // R8
    x8_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_valid_i && fix_en_i && fix_gain_i == 2'd3) |=> (word_o[WORD_W-1:WORD_W-3] == 3'b000));

    // R8
    x1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_valid_i && fix_en_i && fix_gain_i == 2'd0 && !narrow_i)
        |=> (word_o[WORD_W-1:FRAC_W] == $past(adc_data_i)));
endmodule

// File: tb/sim_gain_realign.sv
// Scoreboard bench: the driver pushes expected words, the monitor pops and compares.
module sim_gain_realign;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  vga_gain_i = 2'd0;
    logic [9:0]  adc_data_i = '0;
    logic        adc_valid_i = 1'b0;
    logic        fix_en_i = 1'b0;
    logic [1:0]  fix_gain_i = 2'd0;
    logic        narrow_i = 1'b0;
    logic [12:0] word_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ghist[$];
    logic [12:0] exp_q[$];
    string       tag_q[$];
    int          cyc_q[$];
    logic [12:0] last_word = '0;
    bit          done = 0;

    gain_realign #(.ADC_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .vga_gain_i(vga_gain_i), .adc_data_i(adc_data_i),
        .adc_valid_i(adc_valid_i), .fix_en_i(fix_en_i), .fix_gain_i(fix_gain_i),
        .narrow_i(narrow_i), .word_o(word_o), .valid_o(valid_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one cycle of stimulus; computes the expected word from the requirements
    task automatic drive(input logic [9:0] s, input logic [1:0] g, input bit v,
                         input bit fe, input logic [1:0] fg, input bit nw, input string tag);
        int idx;
        int sh;
        logic [12:0] e;
        @(negedge clk);
        vga_gain_i = g; adc_data_i = s; adc_valid_i = v;
        fix_en_i = fe; fix_gain_i = fg; narrow_i = nw;
        ghist.push_back(int'(g));
        if (v) begin
            idx = ghist.size() - 1 - LAT;
            sh = fe ? int'(fg) : ((idx >= 0) ? ghist[idx] : 0);
            e = {s, 3'b000} >> sh;
            if (nw) e[3:0] = 4'h0;
            exp_q.push_back(e); tag_q.push_back(tag); cyc_q.push_back(cyc + 1);
        end
    endtask

    // monitor: compare outputs against the scoreboard away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 actual=unexpected valid expected=no output");
                end else begin
                    string t;
                    int    c;
                    t = tag_q.pop_front();
                    c = cyc_q.pop_front();
                    check(t, word_o, exp_q.pop_front());
                    checks++;
                    if (c != cyc) begin
                        errors++;
                        $display("FAIL R6 actual=cycle %0d expected=cycle %0d", cyc, c);
                    end
                end
            end else begin
                check("R7 hold", word_o, last_word);
            end
            last_word = word_o;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset valid", {12'd0, valid_o}, 13'd0);
        check("R1 reset word", word_o, 13'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ghist.push_back(0);
        drive(10'h000, 2'd0, 0, 0, 2'd0, 0, "R1");
        #14;
        check("R1 after release", {12'd0, valid_o}, 13'd0);
        for (int i = 0; i < LAT; i++) drive(10'h000, 2'd3, 0, 0, 2'd0, 0, "idle");
        // R2 worked example, auto gain x8 then x1
        drive(10'h333, 2'd0, 1, 0, 2'd0, 0, "R2 x8 example");
        for (int i = 0; i < LAT + 1; i++) drive(10'h000, 2'd0, 0, 0, 2'd0, 0, "idle");
        drive(10'h333, 2'd1, 1, 0, 2'd0, 0, "R2 x1 example");
        // R3 gain changes every cycle, back-to-back samples
        for (int i = 0; i < 24; i++)
            drive(10'(i * 37 + 5), 2'(i * 3 + (i >> 2)), 1, 0, 2'd0, 0, "R3 alignment");
        // R3 sparse samples with gain still moving
        for (int i = 0; i < 12; i++)
            drive(10'(i * 91 + 17), 2'(i), i % 3 == 0, 0, 2'd0, 0, "R3 sparse");
        // R4 fixed gain overrides a changing per-pixel code
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 4; i++)
                drive(10'h2A5 + 10'(i), 2'(i), 1, 1, 2'(f), 0, "R4 fixed");
        // R5 narrow mode, auto and fixed
        for (int i = 0; i < 8; i++)
            drive(10'(i * 113 + 9), 2'(i), 1, i[0], 2'(i >> 1), 1, "R5 narrow");
        drive(10'h3FF, 2'd0, 1, 1, 2'd0, 1, "R5 narrow x1 ones");
        drive(10'h3FF, 2'd0, 1, 1, 2'd3, 1, "R5 narrow x8 ones");
        // R7 gaps
        for (int i = 0; i < 4; i++) drive(10'h155, 2'd2, 0, 0, 2'd0, 0, "R7");
        // R8 boundaries
        for (int g = 0; g < 4; g++) begin
            drive(10'h3FF, 2'd0, 1, 1, 2'(g), 0, "R8 all ones");
            drive(10'h000, 2'd0, 1, 1, 2'(g), 0, "R8 zero");
            drive(10'h201, 2'd0, 1, 1, 2'(g), 0, "R8 edge bits");
        end
        for (int i = 0; i < LAT + 3; i++) drive(10'h000, 2'd0, 0, 0, 2'd0, 0, "drain");
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 actual=%0d pending expected=0 pending", exp_q.size());
        end
        done = 1;
        finish_run();
    end
endmodule